// File: doc/BRIEF.md
# Odd-Width Word Packer for One ALU Lane

This block sits inside a single 64-bit ALU lane, after the stage that routes byte and halfword containers into the lane. On each valid beat it takes the 64-bit lane value and a format code. The lane value holds one character per container: 8-bit containers carry 6-bit characters, and 16-bit containers carry 9-, 10-, 12- or 15-bit characters. The block strips each container's unused upper bits and joins the characters into one contiguous word of 36, 40, 48 or 60 bits. The word is right-justified and zero-filled to the lane width.

Operands of double length (72, 80, 96 or 120 bits) do not fit one lane beat. They arrive as two beats, and each beat is packed as one half. A half flag on the output marks the low beat and the high beat. A format pairing that cannot be built from one lane's containers is reported with an error flag and a zero result. Every result appears one clock after its input beat.

Top module: `oddword_packer`

## Requirements
- R1: While reset (`rst_n` low) is held, and until the first accepted beat, `out_valid`, `out_data`, `out_half` and `out_err` are all zero.
- R2: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low in the cycle after each cycle with `in_valid` low.
- R3: Character j of the word is taken from the low `c` bits of container j, where `c` is the character width and container j occupies `in_data[j*K +: K]`. K is 8 when c is 6 and 16 otherwise. Character j is placed at `out_data[j*c +: c]`. The upper `K-c` bits of every container are ignored.
- R4: For a legal format, every bit of `out_data` at or above the half width is zero. The half width is 36, 40, 48 or 60 for `word_sel[1:0]` = 0, 1, 2 or 3.
- R5: `char_sel` codes 0,1,2,3,4 select character widths 6,9,10,12,15. Codes 5–7 are illegal. The legal pairs (character width, half width) are (6,36), (6,48), (9,36), (10,40), (12,36), (12,48) and (15,60). Every other pair is illegal.
- R6: `word_sel[2]`=1 selects a double-length operand of twice the half width: 72, 80, 96 or 120 bits. Its legal beats alternate the half flag: 0 (low half), then 1 (high half), then 0, and so on. Idle cycles between beats do not break this alternation.
- R7: A single-length legal beat gives `out_half`=0. Any single-length beat or illegal beat restarts the pairing, so the next double-length beat is a low half.
- R8: An illegal beat gives `out_err`=1, `out_data`=0 and `out_half`=0. A legal beat gives `out_err`=0.
- R9: In a cycle after one with `in_valid` low, `out_data`, `out_half` and `out_err` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat strobe |
| in_data | input | 64 | Lane value with one character per container |
| char_sel | input | 3 | Character width code |
| word_sel | input | 3 | Bit 2: double length; bits 1:0: half width code |
| out_valid | output | 1 | Result beat strobe |
| out_data | output | 64 | Packed half, right-justified, zero-filled |
| out_half | output | 1 | 0 low half or single word, 1 high half |
| out_err | output | 1 | Illegal format on this beat |

## Verification
Every result is due exactly one clock edge after the beat that produced it, because a single register stage lies between the ports. The half flag also depends on all earlier legal and illegal beats. The driver computes the expected word, half flag and error bit at the moment it presents a beat, and queues them. The monitor samples on the falling edge. When it sees `out_valid`, it pops the queue, so each result is compared on the cycle it is due. A result that arrives early, arrives late or is missing shows up as an empty queue or a leftover entry. Idle cycles are checked for held outputs.

// File: rtl/pk_pkg.sv
package pk_pkg;

  localparam int unsigned PK_LANE_W   = 64;
  localparam int unsigned PK_N_CHAR   = 5;
  localparam int unsigned PK_SEL_W    = 3;
  localparam int unsigned PK_WIDTH_W  = 7;

  // character widths indexed by char_sel code
  localparam int unsigned PK_CHAR_TAB [PK_N_CHAR] = '{6, 9, 10, 12, 15};

  typedef struct packed {
    logic                  legal;
    logic                  dbl;
    logic [PK_WIDTH_W-1:0] half_w;
    logic [PK_SEL_W-1:0]   char_idx;
  } pk_fmt_t;

  // container width that carries a character of the given width
  function automatic int unsigned pk_cont_w(input int unsigned cw);
    return (cw <= 8) ? 8 : 16;
  endfunction

  // half width from the low bits of the word select
  function automatic logic [PK_WIDTH_W-1:0] pk_half_w(input logic [1:0] code);
    logic [PK_WIDTH_W-1:0] w;
    case (code)
      2'd0:    w = 7'd36;
      2'd1:    w = 7'd40;
      2'd2:    w = 7'd48;
      default: w = 7'd60;
    endcase
    return w;
  endfunction

  // pairs a single lane can hold: count * container <= lane, exact fit
  function automatic logic pk_pair_ok(input logic [PK_SEL_W-1:0] cs,
                                      input logic [1:0]          wc);
    logic ok;
    case ({cs, wc})
      {3'd0, 2'd0}, {3'd0, 2'd2},
      {3'd1, 2'd0},
      {3'd2, 2'd1},
      {3'd3, 2'd0}, {3'd3, 2'd2},
      {3'd4, 2'd3}: ok = 1'b1;
      default:      ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pk_fmt_decode.sv
module pk_fmt_decode
  import pk_pkg::*;
(
  input  logic [PK_SEL_W-1:0] char_sel,
  input  logic [PK_SEL_W-1:0] word_sel,
  output pk_fmt_t             fmt
);

  always_comb begin
    fmt.legal    = pk_pair_ok(char_sel, word_sel[1:0]);
    fmt.dbl      = word_sel[2];
    fmt.half_w   = pk_half_w(word_sel[1:0]);
    fmt.char_idx = fmt.legal ? char_sel : '0;
  end

endmodule

// File: rtl/pk_lane_compact.sv
module pk_lane_compact #(
  parameter int unsigned LANE_W = 64,
  parameter int unsigned CHAR_W = 6,
  parameter int unsigned CONT_W = 8
) (
  input  logic [LANE_W-1:0] lane_i,
  output logic [LANE_W-1:0] packed_o
);

  localparam int unsigned SLOTS = LANE_W / CONT_W;
  localparam int unsigned USED  = SLOTS * CHAR_W;

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    assign packed_o[j*CHAR_W +: CHAR_W] = lane_i[j*CONT_W +: CHAR_W];
  end

  if (USED < LANE_W) begin : g_fill
    assign packed_o[LANE_W-1:USED] = '0;
  end

endmodule

// File: rtl/pk_half_tracker.sv
module pk_half_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic pair_beat,
  output logic half_now,
  output logic phase_q
);

  assign half_now = pair_beat & phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          phase_q <= 1'b0;
    else if (beat)       phase_q <= pair_beat ? ~phase_q : 1'b0;
  end

endmodule

// File: rtl/oddword_packer.sv
module oddword_packer
  import pk_pkg::*;
#(
  parameter int unsigned LANE_W = PK_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [LANE_W-1:0] in_data,
  input  logic [2:0]        char_sel,
  input  logic [2:0]        word_sel,
  output logic              out_valid,
  output logic [LANE_W-1:0] out_data,
  output logic              out_half,
  output logic              out_err
);

  localparam logic [7:0] LANE_W8 = 8'(LANE_W);

  pk_fmt_t fmt;
  logic    fmt_legal;
  logic    pair_beat;
  logic    half_now;
  logic    phase_q;

  logic [LANE_W-1:0] packed_all [PK_N_CHAR];
  logic [LANE_W-1:0] packed_sel;
  logic [LANE_W-1:0] word_mask;
  logic [LANE_W-1:0] word_next;

  function automatic logic [LANE_W-1:0] mask_of(input logic [PK_WIDTH_W-1:0] hw);
    logic [7:0] shamt;
    shamt = 8'(LANE_W8 - {1'b0, hw});
    return {LANE_W{1'b1}} >> shamt;
  endfunction

  pk_fmt_decode u_dec (
    .char_sel (char_sel),
    .word_sel (word_sel),
    .fmt      (fmt)
  );

  assign fmt_legal = fmt.legal;
  assign pair_beat = fmt.legal & fmt.dbl;

  for (genvar k = 0; k < PK_N_CHAR; k++) begin : g_char
    pk_lane_compact #(
      .LANE_W (LANE_W),
      .CHAR_W (PK_CHAR_TAB[k]),
      .CONT_W (pk_cont_w(PK_CHAR_TAB[k]))
    ) u_cmp (
      .lane_i   (in_data),
      .packed_o (packed_all[k])
    );
  end

  always_comb begin
    packed_sel = '0;
    for (int k = 0; k < PK_N_CHAR; k++) begin
      if (fmt.char_idx == PK_SEL_W'(k)) packed_sel = packed_all[k];
    end
    word_mask = mask_of(fmt.half_w);
    word_next = fmt.legal ? (packed_sel & word_mask) : '0;
  end

  pk_half_tracker u_half (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (in_valid),
    .pair_beat (pair_beat),
    .half_now  (half_now),
    .phase_q   (phase_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_half  <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= word_next;
        out_half <= half_now;
        out_err  <= ~fmt.legal;
      end
    end
  end

endmodule

// File: rtl/pk_checker.sv
module pk_checker #(
  parameter int unsigned LANE_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        word_sel,
  input logic              fmt_legal,
  input logic              phase_q,
  input logic              out_valid,
  input logic [LANE_W-1:0] out_data,
  input logic              out_half,
  input logic              out_err
);

  function automatic logic [LANE_W-1:0] upper_bits(input logic [LANE_W-1:0] d,
                                                  input logic [1:0] code);
    case (code)
      2'd0:    return d >> 36;
      2'd1:    return d >> 40;
      2'd2:    return d >> 48;
      default: return d >> 60;
    endcase
  endfunction

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R4
  zero_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_legal) |=> (upper_bits(out_data, $past(word_sel[1:0])) == '0));

  // R6
  pair_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_legal && word_sel[2]) |=> (phase_q != $past(phase_q)));

  // R7
  pair_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(fmt_legal && word_sel[2])) |=> (!phase_q && !out_half));

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_data == '0 && !out_half));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_valid) |=> ($stable(out_data) && $stable(out_half) && $stable(out_err)));

endmodule

bind oddword_packer pk_checker #(.LANE_W(LANE_W)) u_pk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .word_sel  (word_sel),
  .fmt_legal (fmt_legal),
  .phase_q   (phase_q),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_half  (out_half),
  .out_err   (out_err)
);

// File: tb/tb_oddword_packer.sv
module tb_oddword_packer;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG   = 20000;

  typedef struct {
    logic [63:0] data;
    logic        half;
    logic        err;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [2:0]  char_sel = '0;
  logic [2:0]  word_sel = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_half;
  logic        out_err;

  int   n_chk = 0;
  int   n_bad = 0;
  logic model_phase = 1'b0;
  logic done = 1'b0;
  exp_t sb [$];
  logic [63:0] last_data = '0;
  logic        last_half = 1'b0;
  logic        last_err  = 1'b0;

  oddword_packer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .char_sel  (char_sel),
    .word_sel  (word_sel),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_half  (out_half),
    .out_err   (out_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent model of the requirements
  function automatic void model(input logic [2:0] cs, input logic [2:0] ws,
                                input logic [63:0] d, output logic [63:0] res,
                                output logic legal);
    int cw, cont, hw, cnt;
    res = '0;
    case (cs)
      3'd0: cw = 6;  3'd1: cw = 9;  3'd2: cw = 10;
      3'd3: cw = 12; 3'd4: cw = 15; default: cw = 0;
    endcase
    hw    = (ws[1:0] == 0) ? 36 : (ws[1:0] == 1) ? 40 : (ws[1:0] == 2) ? 48 : 60;
    cont  = (cw == 6) ? 8 : 16;
    legal = (cw != 0) && (hw % cw == 0) && ((hw / cw) * cont <= 64);
    if (legal) begin
      cnt = hw / cw;
      for (int i = 0; i < cnt; i++)
        res |= ((d >> (i * cont)) & ((64'd1 << cw) - 64'd1)) << (i * cw);
    end
  endfunction

  task automatic send(input logic [2:0] cs, input logic [2:0] ws,
                      input logic [63:0] d, input string req);
    exp_t e;
    logic [63:0] r;
    logic lg;
    @(negedge clk);
    in_valid = 1'b1; char_sel = cs; word_sel = ws; in_data = d;
    model(cs, ws, d, r, lg);
    e.data = r;
    e.err  = ~lg;
    e.req  = req;
    if (lg && ws[2]) begin
      e.half = model_phase;
      model_phase = ~model_phase;
    end else begin
      e.half = 1'b0;
      model_phase = 1'b0;
    end
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 64'hDEAD_BEEF_0BAD_F00D;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "unexpected out_valid", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_data == e.data, e.req, "out_data", out_data, e.data);
          check(out_half == e.half, e.req, "out_half", 64'(out_half), 64'(e.half));
          check(out_err == e.err, e.req, "out_err", 64'(out_err), 64'(e.err));
        end
      end else if (n_chk > 0) begin
        check(out_data == last_data && out_half == last_half && out_err == last_err,
              "R9", "hold while idle", out_data, last_data);
      end
      last_data = out_data;
      last_half = out_half;
      last_err  = out_err;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_data == 0 && out_half == 0 && out_err == 0,
          "R1", "in reset", out_data, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && out_data == 0 && out_half == 0 && out_err == 0,
          "R1", "after reset", out_data, 64'd0);

    // R3: container upper bits dropped, all-ones lanes
    send(3'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
    send(3'd4, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
    send(3'd1, 3'd0, 64'h8001_4155_7E01_0003, "R3");
    idle(2);

    // R5: every legal pair, varied data, plus all-ones for R4
    for (int t = 0; t < 3; t++) begin
      logic [63:0] d;
      d = (t == 0) ? 64'h0123_4567_89AB_CDEF :
          (t == 1) ? {$urandom, $urandom} : 64'hFFFF_FFFF_FFFF_FFFF;
      send(3'd0, 3'd0, d, "R5");
      send(3'd0, 3'd2, d, "R4");
      send(3'd1, 3'd0, d, "R5");
      send(3'd2, 3'd1, d, "R5");
      send(3'd3, 3'd0, d, "R4");
      send(3'd3, 3'd2, d, "R5");
      send(3'd4, 3'd3, d, "R5");
    end

    // R8: illegal pairs and codes
    send(3'd0, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    send(3'd0, 3'd3, 64'h1234_5678_9ABC_DEF0, "R8");
    send(3'd2, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    send(3'd5, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    send(3'd7, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    idle(1);

    // R6: double-length pairs, with an idle gap inside a pair
    send(3'd1, 3'd4, {$urandom, $urandom}, "R6");
    send(3'd1, 3'd4, {$urandom, $urandom}, "R6");
    send(3'd2, 3'd5, {$urandom, $urandom}, "R6");
    idle(3);
    send(3'd2, 3'd5, {$urandom, $urandom}, "R6");
    send(3'd3, 3'd6, {$urandom, $urandom}, "R6");
    send(3'd3, 3'd6, {$urandom, $urandom}, "R6");
    send(3'd4, 3'd7, {$urandom, $urandom}, "R6");
    send(3'd4, 3'd7, {$urandom, $urandom}, "R6");

    // R7: single and illegal beats restart the pairing
    send(3'd0, 3'd6, {$urandom, $urandom}, "R7");
    send(3'd0, 3'd0, {$urandom, $urandom}, "R7");
    send(3'd0, 3'd6, {$urandom, $urandom}, "R7");
    send(3'd3, 3'd4, {$urandom, $urandom}, "R7");
    send(3'd6, 3'd5, {$urandom, $urandom}, "R7");
    send(3'd3, 3'd4, {$urandom, $urandom}, "R7");
    send(3'd3, 3'd4, {$urandom, $urandom}, "R7");

    idle(4);
    check(sb.size() == 0, "R2", "results outstanding", 64'(sb.size()), 64'd0);
    finish_run();
  end

endmodule